// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block sends characters on a single serial line in asynchronous format. A character written with a one-cycle strobe lands in a holding buffer. When the line is idle and the start conditions are met, the buffer is copied into a shift register. The character then leaves as a framed sequence: a start bit, the data bits least-significant first, an optional parity bit, and one or two stop bits. The buffer is marked empty as soon as it is copied, so software can queue the next character while the current one is still shifting.

The frame format is set at run time. The data length can be 7, 8 or 9 bits, parity can be odd, even or off, and the stop count can be 1 or 2. The format is captured when a character is loaded, so a change made later does not disturb that frame. The bit time comes from an internal generator: the system clock is divided by 1, 8 or 32 and then by 16·(n+1), where n is an 8-bit divisor.

A clear-to-send input can hold off the start of each frame. It never cuts short a frame that has already begun. A one-cycle interrupt pulse marks one of two events, selected by a control bit: the hand-off from buffer to shift register, or the end of the last stop bit.

The controller has six states:
- IDLE holds the line high.
- START drives the start bit.
- DATA shifts out the data bits.
- PAR_BIT sends parity.
- STOP_A and STOP_B send the stop bits.

The transitions are:
- IDLE→START on a launch, when the enable bit is set, the buffer is full and clear-to-send permits.
- START→DATA on a bit tick.
- DATA→PAR_BIT, or DATA→STOP_A when parity is off, on the tick that ends the last data bit.
- PAR_BIT→STOP_A on a tick.
- STOP_A→STOP_B when two stop bits are set, otherwise STOP_A→IDLE, on a tick.
- STOP_B→IDLE on a tick.

Every frame passes through IDLE for at least one cycle before the next one starts.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1 and `tx_irq` is 0.
- R2: A frame is one start bit at 0, then the data bits least-significant first, then the parity bit if enabled, then the stop bits at 1. The line is 1 between frames.
- R3: `len_sel` sets the data length: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits and 3 gives 8 bits. Unused upper bits of `wr_data` are not sent.
- R4: `par_sel` sets parity: 1 is odd, 2 is even, and 0 or 3 means no parity bit. Parity is taken over the configured data bits only. For odd parity the data bits plus the parity bit hold an odd number of ones; for even parity they hold an even number.
- R5: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two.
- R6: Every bit lasts 16·(`div_n`+1)·P clock cycles. P is 1 when `pre_sel` = 0, 8 when `pre_sel` = 1, and 32 when `pre_sel` is 2 or 3.
- R7: A frame starts only while `tx_en` is 1 and the buffer holds a character. With `tx_en` = 0 the line stays high and `buf_empty` stays 0.
- R8: With `cts_en` = 1, a frame starts only while `cts_n` is 0. With `cts_en` = 0, `cts_n` is ignored. A rise of `cts_n` during a frame does not shorten that frame.
- R9: A write sets `buf_empty` to 0 on the next cycle. When the line is idle and the start conditions hold, the frame starts one cycle after the write: `txd` falls and `buf_empty` returns to 1 together. A character written during a frame is sent as the next frame.
- R10: `tx_irq` is a one-cycle pulse. With `irq_sel` = 0 it fires in the cycle the start bit begins. With `irq_sel` = 1 it fires in the cycle after the last stop bit ends, exactly (frame bits)·(bit time) cycles after `txd` fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| wr_stb | input | 1 | One-cycle write strobe for the holding buffer |
| wr_data | input | 9 | Character to send |
| len_sel | input | 2 | Data length select |
| par_sel | input | 2 | Parity mode select |
| two_stop | input | 1 | Two stop bits when 1 |
| pre_sel | input | 2 | Prescaler select (divide by 1, 8 or 32) |
| div_n | input | 8 | Bit-rate divisor n |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low |
| irq_sel | input | 1 | Interrupt event select |
| txd | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding buffer is empty |
| tx_irq | output | 1 | Transmit interrupt pulse |

## Verification
The bench samples every bit at its midpoint across many bits of a frame. A bit time that is off by even one cycle therefore drifts far enough to corrupt the later data or stop samples.

Character values are chosen so that the bits above the configured length have the opposite parity from the bits below it. A design that took parity over all nine bits, or sent the upper bits, would then emit a wrong parity or data bit.

Further tests cover the two hold-off gates and a clear-to-send rise in mid-frame. A design that ignored a gate would start a frame too early; one that honoured the rise mid-frame would truncate the frame.

Back-to-back writes show whether the buffer frees up at launch. The interrupt is timed to the exact cycle for both event selections, which exposes a pulse on the wrong event, a pulse a cycle late, or a pulse two cycles wide.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR_BIT,
        ST_STOP_A,
        ST_STOP_B
    } tx_state_e;

    localparam logic [1:0] PAR_ODD  = 2'd1;
    localparam logic [1:0] PAR_EVEN = 2'd2;

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W    = 8,
    parameter int OVS      = 16,
    parameter int PRE_MID  = 8,
    parameter int PRE_SLOW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [1:0]       pre_sel,
    input  logic [DIV_W-1:0] div_n,
    output logic             bit_tick
);
    localparam int PC_W  = $clog2(PRE_SLOW);
    localparam int OVS_W = $clog2(OVS);
    localparam int CNT_W = DIV_W + OVS_W;

    logic [PC_W-1:0]  pre_cnt;
    logic [PC_W-1:0]  pre_lim;
    logic             pre_tick;
    logic [CNT_W-1:0] div_cnt;
    logic [CNT_W-1:0] div_lim;

    always_comb begin
        unique case (pre_sel)
            2'd0:    pre_lim = '0;
            2'd1:    pre_lim = PC_W'(PRE_MID - 1);
            default: pre_lim = PC_W'(PRE_SLOW - 1);
        endcase
    end

    assign pre_tick = (pre_cnt == pre_lim);
    // limit is 16*(n+1)-1 when OVS is a power of two
    assign div_lim  = {div_n, {OVS_W{1'b1}}};
    assign bit_tick = pre_tick && (div_cnt == div_lim) && !restart;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else begin
            pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
            if (pre_tick) begin
                div_cnt <= (div_cnt == div_lim) ? '0 : div_cnt + 1'b1;
            end
        end
    end

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

endmodule

// File: rtl/sertx_buf.sv
module sertx_buf #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] buf_q,
    output logic              full
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            full  <= 1'b0;
        end else if (wr_stb) begin
            buf_q <= wr_data;
            full  <= 1'b1;
        end else if (take) begin
            full  <= 1'b0;
        end
    end
endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_q,
    input  logic [1:0]        len_sel,
    input  logic [1:0]        par_sel,
    input  logic              two_stop,
    input  logic              cts_en,
    input  logic              cts_n,
    input  logic              irq_sel,
    input  logic              bit_tick,
    output logic              take,
    output logic              txd,
    output logic              tx_irq
);
    localparam int BC_W = $clog2(DATA_W + 1);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shreg;
    logic [BC_W-1:0]   bitcnt;
    logic [BC_W-1:0]   nbits_q, nbits_d;
    logic [DATA_W-1:0] mask_d;
    logic              par_en_q, par_bit_q, two_q;
    logic              go, last_data, frame_done;

    assign go = (state_q == ST_IDLE) && tx_en && buf_full && (!cts_en || !cts_n);
    assign take = go;
    assign last_data = (bitcnt == nbits_q - 1'b1);
    assign frame_done = bit_tick &&
        (((state_q == ST_STOP_A) && !two_q) || (state_q == ST_STOP_B));

    always_comb begin
        nbits_d = (len_sel == 2'd3) ? BC_W'(DATA_W - 1)
                                    : BC_W'(DATA_W - 2) + BC_W'(len_sel);
        for (int i = 0; i < DATA_W; i++) begin
            mask_d[i] = (i < int'(nbits_d));
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (go) state_d = ST_START;
            ST_START:   if (bit_tick) state_d = ST_DATA;
            ST_DATA:    if (bit_tick && last_data)
                            state_d = par_en_q ? ST_PAR_BIT : ST_STOP_A;
            ST_PAR_BIT: if (bit_tick) state_d = ST_STOP_A;
            ST_STOP_A:  if (bit_tick) state_d = two_q ? ST_STOP_B : ST_IDLE;
            ST_STOP_B:  if (bit_tick) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bitcnt    <= '0;
            nbits_q   <= BC_W'(DATA_W - 1);
            par_en_q  <= 1'b0;
            par_bit_q <= 1'b0;
            two_q     <= 1'b0;
            tx_irq    <= 1'b0;
        end else begin
            tx_irq <= (go && !irq_sel) || (frame_done && irq_sel);
            if (go) begin
                shreg     <= buf_q;
                bitcnt    <= '0;
                nbits_q   <= nbits_d;
                par_en_q  <= (par_sel == PAR_ODD) || (par_sel == PAR_EVEN);
                par_bit_q <= (^(buf_q & mask_d)) ^ (par_sel == PAR_ODD);
                two_q     <= two_stop;
            end else if (state_q == ST_DATA && bit_tick) begin
                shreg  <= shreg >> 1;
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_START:   txd = 1'b0;
            ST_DATA:    txd = shreg[0];
            ST_PAR_BIT: txd = par_bit_q;
            default:    txd = 1'b1;
        endcase
    end

    // R2
    start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) != ST_START) |-> $past(state_q) == ST_IDLE);
    // R7
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) == ST_IDLE) |-> ($past(tx_en) && $past(buf_full)));
    // R8
    cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) == ST_IDLE) |-> (!$past(cts_en) || !$past(cts_n)));
    // R10
    irq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !$past(irq_sel)) |-> (state_q == ST_START && $past(state_q) == ST_IDLE));
    // R10
    irq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && $past(irq_sel)) |->
        (state_q == ST_IDLE && ($past(state_q) == ST_STOP_A || $past(state_q) == ST_STOP_B)));

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int DATA_W   = 9,
    parameter int DIV_W    = 8,
    parameter int OVS      = 16,
    parameter int PRE_MID  = 8,
    parameter int PRE_SLOW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        len_sel,
    input  logic [1:0]        par_sel,
    input  logic              two_stop,
    input  logic [1:0]        pre_sel,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              cts_en,
    input  logic              cts_n,
    input  logic              irq_sel,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_irq
);
    logic              take, full, bit_tick;
    logic [DATA_W-1:0] buf_q;

    sertx_buf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .take(take), .buf_q(buf_q), .full(full)
    );

    sertx_baud #(.DIV_W(DIV_W), .OVS(OVS), .PRE_MID(PRE_MID), .PRE_SLOW(PRE_SLOW)) u_baud (
        .clk(clk), .rst_n(rst_n), .restart(take), .pre_sel(pre_sel),
        .div_n(div_n), .bit_tick(bit_tick)
    );

    sertx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .buf_full(full), .buf_q(buf_q),
        .len_sel(len_sel), .par_sel(par_sel), .two_stop(two_stop),
        .cts_en(cts_en), .cts_n(cts_n), .irq_sel(irq_sel), .bit_tick(bit_tick),
        .take(take), .txd(txd), .tx_irq(tx_irq)
    );

    assign buf_empty = !full;

    // R9
    buf_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(take) && !$past(wr_stb)) |-> buf_empty);

endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b1;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic [1:0] cfg_len = 2'd1;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_two = 1'b0;
    logic [1:0] cfg_pre = 2'd0;
    logic [7:0] cfg_div = 8'd0;
    logic       cts_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       irq_sel = 1'b0;
    logic       txd, buf_empty, tx_irq;

    int checks = 0, fails = 0, cyc = 0;
    int fall_cyc = 0, irq_cyc = 0, irq_cnt = 0;
    bit mon_busy = 0, done = 0;
    logic [8:0] exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sertx_top u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb), .wr_data(wr_data),
        .len_sel(cfg_len), .par_sel(cfg_par), .two_stop(cfg_two), .pre_sel(cfg_pre),
        .div_n(cfg_div), .cts_en(cts_en), .cts_n(cts_n), .irq_sel(irq_sel),
        .txd(txd), .buf_empty(buf_empty), .tx_irq(tx_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bit_time();
        int p = (cfg_pre == 2'd0) ? 1 : (cfg_pre == 2'd1) ? 8 : 32;
        return 16 * (int'(cfg_div) + 1) * p;
    endfunction

    function automatic int nbits();
        return (cfg_len == 2'd0) ? 7 : (cfg_len == 2'd2) ? 9 : 8;
    endfunction

    function automatic bit par_on();
        return (cfg_par == 2'd1) || (cfg_par == 2'd2);
    endfunction

    function automatic int frame_bits();
        return 1 + nbits() + (par_on() ? 1 : 0) + (cfg_two ? 2 : 1);
    endfunction

    // driver: queue the expected character, then strobe it in
    task automatic send(input logic [8:0] d);
        @(negedge clk);
        exp_q.push_back(d);
        wr_data = d;
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || mon_busy) @(negedge clk);
        repeat (bit_time() + 4) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (tx_irq) begin
            irq_cnt <= irq_cnt + 1;
            irq_cyc <= cyc;
        end
    end

    // monitor: samples each bit at its midpoint and compares with the queue
    initial begin
        logic [8:0] got, exp, mask;
        int bp;
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                mon_busy = 1;
                fall_cyc = cyc;
                bp = bit_time();
                got = '0;
                exp = '0;
                mask = '0;
                for (int i = 0; i < nbits(); i++) mask[i] = 1'b1;
                repeat (bp / 2) @(negedge clk);
                chk(txd == 1'b0, "R2 start bit low", txd, 0);
                for (int i = 0; i < nbits(); i++) begin
                    repeat (bp) @(negedge clk);
                    got[i] = txd;
                end
                if (exp_q.size() == 0) begin
                    chk(0, "R7 unexpected frame", got, 0);
                end else begin
                    exp = exp_q.pop_front();
                    chk(got == (exp & mask), "R3 data bits lsb first", got, exp & mask);
                end
                if (par_on()) begin
                    repeat (bp) @(negedge clk);
                    chk(txd == ((^(exp & mask)) ^ (cfg_par == 2'd1)), "R4 parity bit",
                        txd, (^(exp & mask)) ^ (cfg_par == 2'd1));
                end
                repeat (bp) @(negedge clk);
                chk(txd == 1'b1, "R5 first stop bit", txd, 1);
                if (cfg_two) begin
                    repeat (bp) @(negedge clk);
                    chk(txd == 1'b1, "R5 second stop bit", txd, 1);
                end
                mon_busy = 0;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(txd == 1'b1, "R1 txd idle", txd, 1);
        chk(buf_empty == 1'b1, "R1 buffer empty", buf_empty, 1);
        chk(tx_irq == 1'b0, "R1 irq low", tx_irq, 0);

        // R9 one-cycle launch timing and R10 load interrupt, 8N1, 16 cycles per bit
        irq_cnt = 0;
        @(negedge clk);
        exp_q.push_back(9'h0A5);
        wr_data = 9'h0A5; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(buf_empty == 1'b0, "R9 buffer full after write", buf_empty, 0);
        chk(txd == 1'b1, "R9 line high before launch", txd, 1);
        @(negedge clk);
        chk(buf_empty == 1'b1, "R9 buffer freed at launch", buf_empty, 1);
        chk(tx_irq == 1'b1, "R10 load interrupt", tx_irq, 1);
        drain();
        chk(irq_cnt == 1, "R10 single pulse at load", irq_cnt, 1);
        chk(irq_cyc == fall_cyc, "R10 load irq with start", irq_cyc - fall_cyc, 0);

        // R3 R4: 7 bits even parity; upper bits would flip parity
        cfg_len = 2'd0; cfg_par = 2'd2;
        send(9'h0D3);
        drain();
        // R3 R4 R5: 9 bits odd parity two stops
        cfg_len = 2'd2; cfg_par = 2'd1; cfg_two = 1'b1;
        send(9'h1A5);
        drain();
        // R3 R4: length code 3 is 8 bits, parity code 3 is none
        cfg_len = 2'd3; cfg_par = 2'd3; cfg_two = 1'b0;
        send(9'h13C);
        drain();

        // R6: prescaler 8, then divisor 2, then prescaler 32
        cfg_len = 2'd1; cfg_par = 2'd2; cfg_pre = 2'd1; cfg_div = 8'd0;
        send(9'h05A);
        drain();
        cfg_pre = 2'd0; cfg_div = 8'd2; cfg_par = 2'd0;
        send(9'h0C3);
        drain();
        cfg_pre = 2'd2; cfg_div = 8'd0;
        send(9'h081);
        drain();
        cfg_pre = 2'd0; cfg_div = 8'd0;

        // R7: enable low holds the frame
        tx_en = 1'b0;
        send(9'h066);
        repeat (300) @(negedge clk);
        chk(txd == 1'b1, "R7 held while disabled", txd, 1);
        chk(buf_empty == 1'b0, "R7 buffer kept", buf_empty, 0);
        tx_en = 1'b1;
        drain();

        // R8: clear-to-send gating
        cts_en = 1'b1; cts_n = 1'b1;
        send(9'h099);
        repeat (300) @(negedge clk);
        chk(txd == 1'b1, "R8 held by cts", txd, 1);
        chk(buf_empty == 1'b0, "R8 buffer kept", buf_empty, 0);
        cts_n = 1'b0;
        while (txd == 1'b1) @(negedge clk);
        repeat (40) @(negedge clk);
        cts_n = 1'b1;   // mid-frame rise must not cut the frame
        drain();
        cts_en = 1'b0;  // ignored when disabled
        send(9'h0F0);
        drain();

        // R9: back-to-back characters
        send(9'h011);
        while (buf_empty == 1'b0) @(negedge clk);
        send(9'h0EE);
        drain();

        // R10: end-of-frame interrupt
        irq_sel = 1'b1; irq_cnt = 0;
        send(9'h03C);
        drain();
        chk(irq_cnt == 1, "R10 single pulse at end", irq_cnt, 1);
        chk(irq_cyc - fall_cyc == frame_bits() * bit_time(), "R10 end irq timing",
            irq_cyc - fall_cyc, frame_bits() * bit_time());
        cfg_par = 2'd1; cfg_two = 1'b1; irq_cnt = 0;
        send(9'h0B2);
        drain();
        chk(irq_cnt == 1, "R10 single pulse with parity and two stops", irq_cnt, 1);
        chk(irq_cyc - fall_cyc == frame_bits() * bit_time(), "R10 end irq timing long frame",
            irq_cyc - fall_cyc, frame_bits() * bit_time());

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule